// File: doc/BRIEF.md
# Constant-Dissipation Reference Calculator

This block sets the voltage target handed to the inner regulation loop of a switching converter that feeds a linear post-regulator. The block keeps the voltage dropped across that post-regulator just large enough for its dissipation to sit at a fixed power. The dissipation is the product of the drop and the load current. The target therefore equals the measured output voltage plus a headroom term, and that term is the fixed power divided by the measured current.

No divider is built. The headroom term is read from a reciprocal table. The table is filled at elaboration from a scale constant, and its address is the most significant bits of the current code. A zero-current address cannot produce an infinite term, so it returns the largest allowed headroom. Every table entry is also clipped to that same maximum. The sum of voltage and headroom is clipped to the full-scale reference code rather than wrapping.

Each sample arrives with a valid strobe. Its result leaves two clock cycles later with its own strobe. When no result is produced, the output keeps its previous value.

Top module: `pwr_ref_calc`

## Requirements
- R1: For a sample with voltage code V and current code I, the result is V + H(I >> 4), where H(n) = min(HEAD_K / n, HEAD_MAX) with integer division, HEAD_K = 4096 and HEAD_MAX = 1023 by default.
- R2: When the table address I >> 4 is 0, the headroom used is HEAD_MAX (1023).
- R3: When V + H exceeds 4095, the result is 4095, and a result is never smaller than its V.
- R4: `res_valid` is high in a cycle exactly when `smp_valid` was high two rising edges earlier.
- R5: The result belonging to a sample appears on `vref` in the same cycle as its `res_valid`, with back-to-back samples each giving their own result.
- R6: In cycles where `res_valid` is low, `vref` keeps the last result.
- R7: A synchronous active-high reset sets `vref` to 0 and `res_valid` to 0.
- R8: The four least significant bits of the current code have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| vout_code | input | 12 | Measured output voltage code |
| iout_code | input | 12 | Measured output current code |
| vref | output | 12 | Reference for the inner loop |
| res_valid | output | 1 | Result strobe |

## Verification
Two behaviours can occur in the same sample: the zero-current table entry and the full-scale clip. A zero current returns the largest headroom, and adding it to a high voltage code pushes the sum past full scale. The bench sends a sample with current code 0 and voltage code 3500, and it expects exactly 4095. A sample at voltage code 3000 checks the zero-current entry on its own (expected 4023). A behavioural model compares strobe and reference on every clock across idle gaps and back-to-back bursts.

// File: rtl/pwr_ref_pkg.sv
package pwr_ref_pkg;

    localparam int VOLT_W = 12;
    localparam int AMP_W  = 12;
    localparam int IDX_W  = 8;
    localparam int HEAD_W = 10;
    localparam int REF_W  = 12;

    localparam int ROM_N   = 1 << IDX_W;
    localparam int REF_MAX = (1 << REF_W) - 1;
    localparam int SUM_W   = REF_W + 1;

    typedef logic [VOLT_W-1:0] volt_t;
    typedef logic [AMP_W-1:0]  amp_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [HEAD_W-1:0] head_t;
    typedef logic [REF_W-1:0]  ref_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic  valid;
        volt_t vout;
        head_t head;
    } stage1_t;

    // Table address: upper bits of the current code.
    function automatic idx_t amp_to_idx(amp_t a);
        return a[AMP_W-1 -: IDX_W];
    endfunction

    // Headroom entry: scale constant over address, clipped; address 0 gives the maximum.
    function automatic head_t head_entry(int idx, int k, int hmax);
        int q;
        if (idx == 0) return head_t'(hmax);
        q = k / idx;
        if (q > hmax) q = hmax;
        return head_t'(q);
    endfunction

    // Voltage plus headroom, clipped at full scale.
    function automatic ref_t sat_add(volt_t v, head_t h);
        sum_t s;
        s = sum_t'(v) + sum_t'(h);
        if (s > sum_t'(REF_MAX)) return ref_t'(REF_MAX);
        return s[REF_W-1:0];
    endfunction

endpackage

// File: rtl/pwr_ref_recip_rom.sv
module pwr_ref_recip_rom
    import pwr_ref_pkg::*;
#(
    parameter int HEAD_K   = 4096,
    parameter int HEAD_MAX = 1023
) (
    input  idx_t  idx,
    output head_t head
);

    head_t table_q [ROM_N];

    for (genvar g = 0; g < ROM_N; g++) begin : g_entry
        assign table_q[g] = head_entry(g, HEAD_K, HEAD_MAX);
    end

    assign head = table_q[idx];

    always_comb begin
        if (idx == '0) begin
            assert_zero_current_R2: assert (head == head_t'(HEAD_MAX));
        end
    end

endmodule

// File: rtl/pwr_ref_sum.sv
module pwr_ref_sum
    import pwr_ref_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  stage1_t st,
    output ref_t    ref_q,
    output logic    valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= st.valid;
            if (st.valid) begin
                ref_q <= sat_add(st.vout, st.head);
            end
        end
    end

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        st.valid |=> (ref_q >= ref_t'($past(st.vout))));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !st.valid |=> $stable(ref_q));

endmodule

// File: rtl/pwr_ref_calc.sv
module pwr_ref_calc
    import pwr_ref_pkg::*;
#(
    parameter int HEAD_K   = 4096,
    parameter int HEAD_MAX = 1023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [VOLT_W-1:0] vout_code,
    input  logic [AMP_W-1:0]  iout_code,
    output logic [REF_W-1:0]  vref,
    output logic              res_valid
);

    head_t   head_c;
    stage1_t s1_q;

    pwr_ref_recip_rom #(
        .HEAD_K   (HEAD_K),
        .HEAD_MAX (HEAD_MAX)
    ) i_rom (
        .idx  (amp_to_idx(iout_code)),
        .head (head_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= smp_valid;
            s1_q.vout  <= vout_code;
            s1_q.head  <= head_c;
        end
    end

    pwr_ref_sum i_sum (
        .clk     (clk),
        .rst     (rst),
        .st      (s1_q),
        .ref_q   (vref),
        .valid_q (res_valid)
    );

    assert_valid_lat_R4: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> ##1 res_valid);

    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ##1 !res_valid);

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (vref == '0 && !res_valid));

    assert_head_floor_R3: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid |=> (vref >= ref_t'($past(s1_q.head))));

endmodule

// File: tb/test_pwr_ref_calc.sv
module test_pwr_ref_calc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] vout_code = '0;
    logic [11:0] iout_code = '0;
    logic [11:0] vref;
    logic        res_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pwr_ref_calc i_pwr_ref_calc (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .vout_code (vout_code),
        .iout_code (iout_code),
        .vref      (vref),
        .res_valid (res_valid)
    );

    function automatic int head_of(int i);
        int n;
        int q;
        n = i / 16;
        if (n == 0) return 1023;
        q = 4096 / n;
        return (q > 1023) ? 1023 : q;
    endfunction

    function automatic int expect_ref(int v, int i);
        int s;
        s = v + head_of(i);
        return (s > 4095) ? 4095 : s;
    endfunction

    // Behavioural model
    int  m_ref = 0;
    bit  m_val = 0;
    bit  p_val = 0;
    int  p_v = 0;
    int  p_i = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ref = 0; m_val = 0; p_val = 0; p_v = 0; p_i = 0;
        end else begin
            if (p_val) m_ref = expect_ref(p_v, p_i);
            m_val = p_val;
            p_val = smp_valid;
            p_v   = int'(vout_code);
            p_i   = int'(iout_code);
        end
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R4, R5, R6)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 strobe", int'(res_valid), int'(m_val));
            if (m_val) check("R5 result", int'(vref), m_ref);
            else       check("R6 hold", int'(vref), m_ref);
        end
    end

    task automatic send(int v, int i, int exp, string req);
        @(negedge clk);
        smp_valid = 1'b1; vout_code = 12'(v); iout_code = 12'(i);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        check(req, int'(vref), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 ref", int'(vref), 0);
        check("R7 valid", int'(res_valid), 0);
        rst = 1'b0;

        send(100, 12'h050, 919, "R1");
        send(100, 12'h05F, 919, "R8");
        send(3000, 12'h000, 4023, "R2");
        send(3500, 12'h000, 4095, "R3 R2 zero current clip");
        send(3500, 12'h00F, 4095, "R8 low bits at zero");
        send(4000, 12'h100, 4095, "R3");
        send(0, 12'hFF0, 16, "R1 top address");
        repeat (4) @(negedge clk);
        check("R6 idle", int'(vref), 16);

        // back-to-back burst
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            vout_code = 12'((k * 397) % 4096);
            iout_code = 12'((k * 1231 + 7) % 4096);
        end
        @(negedge clk);
        smp_valid = 1'b0;

        // mixed gaps
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            smp_valid = ((k % 3) != 1);
            vout_code = 12'((k * 2711 + 5) % 4096);
            iout_code = 12'((k * 53) % 4096);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (4) @(negedge clk);

        // reset mid-stream
        @(negedge clk);
        smp_valid = 1'b1; vout_code = 12'd500; iout_code = 12'h200;
        rst = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R7 mid reset ref", int'(vref), 0);
        check("R7 mid reset valid", int'(res_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 no stale result", int'(res_valid), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule